// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block keeps the exception state of an in-order five-stage pipeline: fetch, decode, execute, memory and writeback. It owns the fetch program counter. Each instruction moves one stage per cycle and carries its PC and a cause code. A fault that is detected in a stage does not change the pipeline's flow at that time. The fault is attached to the instruction as a tag. The tag is acted on only when the instruction reaches the commit point, which is the writeback stage.

At the commit point the controller chooses one of two actions. It can let the instruction retire, which allows its register and memory writes. Or it can take a trap. To take a trap it records the cause and the instruction's PC, turns every stage into a bubble, suppresses the committing instruction's writes and restarts fetch at a fixed handler address. An external interrupt line is sampled only at the commit point, and it wins over any fault carried by the instruction there. Arithmetic, memories and the instruction stream are outside the block. The surrounding datapath reports faults and uses `commit_o` as its write enable.

Top module: `exc_commit_ctrl`

## Requirements
- R1: During reset and directly after it, `fetch_pc_o` equals RESET_PC, every stage is empty, `cause_o` is 0, `epc_o` is 0, and both `exc_take_o` and `commit_o` are low.
- R2: While `fetch_en_i` is high, `fetch_pc_o` increases by PC_STEP in each cycle without a trap. The fetched instruction appears in decode one cycle later and then moves one stage per cycle. `stage_valid_o` bit 0 is decode, bit 1 is execute, bit 2 is memory and bit 3 is writeback.
- R3: A fault is seen on `fault_i` bit k while stage k holds a valid instruction. Stage k is fetch for k=0, decode for 1, execute for 2 and memory for 3. The fault tags that instruction with cause k+1: 1 is a fetch address fault, 2 is an illegal opcode, 3 is an overflow and 4 is a data address fault. No trap happens before the instruction reaches writeback.
- R4: Each instruction keeps the first cause it was tagged with. A fault in a later stage does not replace it.
- R5: `exc_take_o` is high in the same cycle that writeback holds a valid instruction that has a nonzero cause or sees `irq_i` high. In that cycle `commit_o` is low.
- R6: When `irq_i` is high at a trap, the recorded cause is 5, and it replaces the instruction's own cause.
- R7: From the cycle after a trap, `cause_o` holds the recorded cause and `epc_o` holds the PC of the instruction that was in writeback. Both keep their values until the next trap.
- R8: In the cycle after a trap, all four stages are empty and `fetch_pc_o` equals HANDLER_PC.
- R9: An empty stage never raises a trap. Faults on empty stages are ignored, and `irq_i` has no effect while writeback is empty.
- R10: A valid instruction in writeback with cause 0 and `irq_i` low commits. `commit_o` is high and `commit_pc_o` gives its PC.
- R11: An older instruction's trap comes before that of any younger instruction, even if the younger one was tagged first. The younger instructions never commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_en_i | input | 1 | An instruction is fetched at `fetch_pc_o` in this cycle |
| fault_i | input | 4 | Fault per stage: bit 0 fetch, 1 decode, 2 execute, 3 memory |
| irq_i | input | 1 | External interrupt, seen at the commit point |
| fetch_pc_o | output | PC_W | PC currently being fetched |
| stage_valid_o | output | 4 | Occupancy of decode, execute, memory and writeback |
| commit_o | output | 1 | The writeback instruction retires; enables its writes |
| commit_pc_o | output | PC_W | PC of the instruction in writeback |
| exc_take_o | output | 1 | A trap is taken in this cycle |
| cause_o | output | 3 | Recorded trap cause |
| epc_o | output | PC_W | Recorded PC of the trapped instruction |

## Verification
A wrong cause tag inside the pipeline cannot be seen at once. It shows up at `cause_o` one cycle after the instruction reaches writeback, so up to five cycles after the fault that caused it. A wrong occupancy bit shows on `stage_valid_o` in the next cycle. It shows later as a missing or extra `commit_o`, or as a trap where none was due. A bad redirect shows on `fetch_pc_o` in the cycle right after `exc_take_o`. A reference model is compared with every output in every cycle, so any of these errors is reported within a few cycles of the cause.

// File: rtl/exc_commit_pkg.sv
package exc_commit_pkg;

   typedef enum logic [2:0] {
      EXC_NONE       = 3'd0,
      EXC_FETCH_ADDR = 3'd1,
      EXC_ILLEGAL    = 3'd2,
      EXC_OVERFLOW   = 3'd3,
      EXC_DATA_ADDR  = 3'd4,
      EXC_EXT_IRQ    = 3'd5
   } exc_cause_e;

   localparam int CAUSE_W = 3;

   // cause code that a fault seen in stage k attaches to its instruction
   function automatic logic [CAUSE_W-1:0] stage_fault_code(input int k);
      return CAUSE_W'(k + 1);
   endfunction

endpackage

// File: rtl/exc_fetch_pc.sv
module exc_fetch_pc #(
   parameter int          PC_W       = 32,
   parameter logic [63:0] RESET_PC   = 64'h1000,
   parameter logic [63:0] HANDLER_PC = 64'h0180,
   parameter int          PC_STEP    = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            advance_i,
   input  logic            redirect_i,
   output logic [PC_W-1:0] pc_o
);

   localparam logic [PC_W-1:0] STEP_V    = PC_W'(PC_STEP);
   localparam logic [PC_W-1:0] RESET_V   = RESET_PC[PC_W-1:0];
   localparam logic [PC_W-1:0] HANDLER_V = HANDLER_PC[PC_W-1:0];

   logic [PC_W-1:0] pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= RESET_V;
      end else if (redirect_i) begin
         pc_q <= HANDLER_V;
      end else if (advance_i) begin
         pc_q <= pc_q + STEP_V;
      end
   end

   assign pc_o = pc_q;

endmodule

// File: rtl/exc_pipe_stage.sv
module exc_pipe_stage
   import exc_commit_pkg::*;
#(
   parameter int                 PC_W       = 32,
   parameter logic [CAUSE_W-1:0] FAULT_CODE = 3'd1,
   parameter bit                 KILL_SCRUB = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               kill_i,
   input  logic               valid_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic               fault_i,
   output logic               valid_o,
   output logic [PC_W-1:0]    pc_o,
   output logic [CAUSE_W-1:0] cause_o
);

   logic               valid_q;
   logic [PC_W-1:0]    pc_q;
   logic [CAUSE_W-1:0] cause_q;
   logic [CAUSE_W-1:0] cause_d;

   // the first fault wins: a cause that is already set is never replaced
   always_comb begin
      cause_d = cause_i;
      if (valid_i && fault_i && (cause_i == EXC_NONE)) begin
         cause_d = FAULT_CODE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else begin
         valid_q <= valid_i & ~kill_i;
      end
   end

   generate
      if (KILL_SCRUB) begin : g_scrub
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pc_q    <= '0;
               cause_q <= EXC_NONE;
            end else if (kill_i) begin
               pc_q    <= '0;
               cause_q <= EXC_NONE;
            end else begin
               pc_q    <= pc_i;
               cause_q <= cause_d;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pc_q    <= '0;
               cause_q <= EXC_NONE;
            end else begin
               pc_q    <= pc_i;
               cause_q <= cause_d;
            end
         end
      end
   endgenerate

   assign valid_o = valid_q;
   assign pc_o    = pc_q;
   assign cause_o = cause_q;

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
   import exc_commit_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               w_valid_i,
   input  logic [PC_W-1:0]    w_pc_i,
   input  logic [CAUSE_W-1:0] w_cause_i,
   input  logic               irq_i,
   output logic               take_o,
   output logic               commit_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [PC_W-1:0]    epc_o
);

   logic               take;
   logic [CAUSE_W-1:0] trap_code;
   logic [CAUSE_W-1:0] cause_q;
   logic [PC_W-1:0]    epc_q;

   // the interrupt outranks the instruction's own fault
   always_comb begin
      take      = w_valid_i && (irq_i || (w_cause_i != EXC_NONE));
      trap_code = irq_i ? EXC_EXT_IRQ : w_cause_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= EXC_NONE;
         epc_q   <= '0;
      end else if (take) begin
         cause_q <= trap_code;
         epc_q   <= w_pc_i;
      end
   end

   assign take_o   = take;
   assign commit_o = w_valid_i && !take;
   assign cause_o  = cause_q;
   assign epc_o    = epc_q;

endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
   import exc_commit_pkg::*;
#(
   parameter int          PC_W       = 32,
   parameter logic [63:0] RESET_PC   = 64'h1000,
   parameter logic [63:0] HANDLER_PC = 64'h0180,
   parameter int          PC_STEP    = 4,
   parameter bit          KILL_SCRUB = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fetch_en_i,
   input  logic [3:0]         fault_i,
   input  logic               irq_i,
   output logic [PC_W-1:0]    fetch_pc_o,
   output logic [3:0]         stage_valid_o,
   output logic               commit_o,
   output logic [PC_W-1:0]    commit_pc_o,
   output logic               exc_take_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [PC_W-1:0]    epc_o
);

   localparam int NUM_SRC = 4;        // fetch, decode, execute, memory
   localparam int NUM_REG = NUM_SRC;  // decode .. writeback registers
   localparam int WB      = NUM_REG - 1;

   generate
      if (PC_W < 8 || PC_W > 64) begin : g_bad_pc_w
         $error("PC_W out of range");
      end
      if (PC_STEP <= 0 || (PC_STEP & (PC_STEP - 1)) != 0) begin : g_bad_step
         $error("PC_STEP must be a power of two");
      end
      if ((HANDLER_PC % PC_STEP) != 0 || (RESET_PC % PC_STEP) != 0) begin : g_bad_align
         $error("reset and handler PCs must be PC_STEP aligned");
      end
   endgenerate

   logic                             kill;
   logic [PC_W-1:0]                  f_pc;
   logic [NUM_REG-1:0]               in_valid;
   logic [NUM_REG-1:0][PC_W-1:0]     in_pc;
   logic [NUM_REG-1:0][CAUSE_W-1:0]  in_cause;
   logic [NUM_REG-1:0]               st_valid;
   logic [NUM_REG-1:0][PC_W-1:0]     st_pc;
   logic [NUM_REG-1:0][CAUSE_W-1:0]  st_cause;

   exc_fetch_pc #(
      .PC_W       (PC_W),
      .RESET_PC   (RESET_PC),
      .HANDLER_PC (HANDLER_PC),
      .PC_STEP    (PC_STEP)
   ) i_fetch_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .advance_i  (fetch_en_i),
      .redirect_i (kill),
      .pc_o       (f_pc)
   );

   generate
      for (genvar j = 0; j < NUM_REG; j++) begin : g_stage
         if (j == 0) begin : g_from_fetch
            assign in_valid[j] = fetch_en_i;
            assign in_pc[j]    = f_pc;
            assign in_cause[j] = EXC_NONE;
         end else begin : g_from_prev
            assign in_valid[j] = st_valid[j-1];
            assign in_pc[j]    = st_pc[j-1];
            assign in_cause[j] = st_cause[j-1];
         end

         exc_pipe_stage #(
            .PC_W       (PC_W),
            .FAULT_CODE (stage_fault_code(j)),
            .KILL_SCRUB (KILL_SCRUB)
         ) i_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .kill_i  (kill),
            .valid_i (in_valid[j]),
            .pc_i    (in_pc[j]),
            .cause_i (in_cause[j]),
            .fault_i (fault_i[j]),
            .valid_o (st_valid[j]),
            .pc_o    (st_pc[j]),
            .cause_o (st_cause[j])
         );
      end
   endgenerate

   exc_commit_unit #(
      .PC_W (PC_W)
   ) i_commit (
      .clk       (clk),
      .rst_n     (rst_n),
      .w_valid_i (st_valid[WB]),
      .w_pc_i    (st_pc[WB]),
      .w_cause_i (st_cause[WB]),
      .irq_i     (irq_i),
      .take_o    (kill),
      .commit_o  (commit_o),
      .cause_o   (cause_o),
      .epc_o     (epc_o)
   );

   assign fetch_pc_o    = f_pc;
   assign stage_valid_o = st_valid;
   assign commit_pc_o   = st_pc[WB];
   assign exc_take_o    = kill;

endmodule

// File: rtl/exc_commit_ctrl_chk.sv
module exc_commit_ctrl_chk #(
   parameter int          PC_W       = 32,
   parameter logic [63:0] HANDLER_PC = 64'h0180
) (
   input logic            clk,
   input logic            rst_n,
   input logic            fetch_en_i,
   input logic [3:0]      fault_i,
   input logic            irq_i,
   input logic [PC_W-1:0] fetch_pc_o,
   input logic [3:0]      stage_valid_o,
   input logic            commit_o,
   input logic [PC_W-1:0] commit_pc_o,
   input logic            exc_take_o,
   input logic [2:0]      cause_o,
   input logic [PC_W-1:0] epc_o,
   input logic [3:0][2:0] st_cause
);

   assert_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take_o |=> (stage_valid_o == 4'b0000) && (fetch_pc_o == HANDLER_PC[PC_W-1:0]));

   assert_no_commit_on_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(exc_take_o && commit_o));

   assert_trap_needs_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take_o |-> stage_valid_o[3]);

   assert_epc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take_o |=> epc_o == $past(commit_pc_o));

   assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_take_o && irq_i) |=> cause_o == 3'd5);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_take_o |=> $stable(cause_o) && $stable(epc_o));

   assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_take_o |=> stage_valid_o[3:1] == $past(stage_valid_o[2:0]));

   assert_fetch_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_en_i && fault_i[0] && !exc_take_o) |=> st_cause[0] == 3'd1);

   generate
      for (genvar j = 0; j < 3; j++) begin : g_keep_first
         assert_first_cause_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (stage_valid_o[j] && (st_cause[j] != 3'd0) && !exc_take_o)
            |=> st_cause[j+1] == $past(st_cause[j]));
      end
   endgenerate

endmodule

bind exc_commit_ctrl exc_commit_ctrl_chk #(
   .PC_W       (PC_W),
   .HANDLER_PC (HANDLER_PC)
) i_exc_commit_ctrl_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fetch_en_i    (fetch_en_i),
   .fault_i       (fault_i),
   .irq_i         (irq_i),
   .fetch_pc_o    (fetch_pc_o),
   .stage_valid_o (stage_valid_o),
   .commit_o      (commit_o),
   .commit_pc_o   (commit_pc_o),
   .exc_take_o    (exc_take_o),
   .cause_o       (cause_o),
   .epc_o         (epc_o),
   .st_cause      (st_cause)
);

// File: tb/test_exc_commit_ctrl.sv
module test_exc_commit_ctrl;

   localparam int          CLK_PERIOD = 10;
   localparam int          PC_W       = 32;
   localparam logic [63:0] RESET_PC   = 64'h1000;
   localparam logic [63:0] HANDLER_PC = 64'h0180;
   localparam int          PC_STEP    = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            fetch_en_i = 1'b0;
   logic [3:0]      fault_i = 4'b0;
   logic            irq_i = 1'b0;
   logic [PC_W-1:0] fetch_pc_o;
   logic [3:0]      stage_valid_o;
   logic            commit_o;
   logic [PC_W-1:0] commit_pc_o;
   logic            exc_take_o;
   logic [2:0]      cause_o;
   logic [PC_W-1:0] epc_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_commit_ctrl #(
      .PC_W       (PC_W),
      .RESET_PC   (RESET_PC),
      .HANDLER_PC (HANDLER_PC),
      .PC_STEP    (PC_STEP)
   ) i_exc_commit_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .fetch_en_i    (fetch_en_i),
      .fault_i       (fault_i),
      .irq_i         (irq_i),
      .fetch_pc_o    (fetch_pc_o),
      .stage_valid_o (stage_valid_o),
      .commit_o      (commit_o),
      .commit_pc_o   (commit_pc_o),
      .exc_take_o    (exc_take_o),
      .cause_o       (cause_o),
      .epc_o         (epc_o)
   );

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   // behavioural reference: index 0 decode .. 3 writeback
   bit              mv [4];
   logic [PC_W-1:0] mpc [4];
   int              mc [4];
   logic [PC_W-1:0] mpcf;
   int              mcq;
   logic [PC_W-1:0] mepc;
   bit              prev_take;
   logic [31:0]     rng = 32'h1234_5678;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] next_rand();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      return rng;
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 4; k++) begin
         mv[k] = 1'b0; mpc[k] = '0; mc[k] = 0;
      end
      mpcf = RESET_PC[PC_W-1:0];
      mcq = 0; mepc = '0; prev_take = 1'b0;
   endtask

   task automatic step(input bit fe, input bit [3:0] flt, input bit irq);
      bit take;
      @(negedge clk);
      fetch_en_i = fe; fault_i = flt; irq_i = irq;
      #1;
      take = mv[3] && (irq || mc[3] != 0);
      chk(prev_take ? "R8 fetch pc after trap" : "R2 fetch pc", fetch_pc_o, mpcf);
      chk(prev_take ? "R8 stages empty after trap" : "R2 stage occupancy",
          stage_valid_o, {mv[3], mv[2], mv[1], mv[0]});
      chk("R5 R9 trap taken", exc_take_o, take);
      chk("R10 R11 commit", commit_o, mv[3] && !take);
      if (mv[3]) chk("R10 commit pc", commit_pc_o, mpc[3]);
      chk("R3 R4 R6 R7 recorded cause", cause_o, mcq);
      chk("R7 recorded epc", epc_o, mepc);
      // advance the reference by one clock
      if (take) begin
         mcq  = irq ? 5 : mc[3];
         mepc = mpc[3];
         for (int k = 0; k < 4; k++) mv[k] = 1'b0;
         mpcf = HANDLER_PC[PC_W-1:0];
      end else begin
         for (int k = 3; k > 0; k--) begin
            mc[k]  = (mv[k-1] && flt[k] && mc[k-1] == 0) ? k + 1 : mc[k-1];
            mv[k]  = mv[k-1];
            mpc[k] = mpc[k-1];
         end
         mv[0]  = fe;
         mpc[0] = mpcf;
         mc[0]  = (fe && flt[0]) ? 1 : 0;
         if (fe) mpcf = mpcf + PC_W'(PC_STEP);
      end
      prev_take = take;
   endtask

   initial begin
      model_reset();
      // R1: state held under reset
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         chk("R1 reset fetch pc", fetch_pc_o, RESET_PC[PC_W-1:0]);
         chk("R1 reset stages", stage_valid_o, 4'b0000);
         chk("R1 reset cause", cause_o, 3'd0);
         chk("R1 reset epc", epc_o, '0);
         chk("R1 reset take", exc_take_o, 1'b0);
         chk("R1 reset commit", commit_o, 1'b0);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R2 R10: clean stream
      for (int i = 0; i < 8; i++) step(1'b1, 4'b0000, 1'b0);
      for (int i = 0; i < 4; i++) step(1'b0, 4'b0000, 1'b0);

      // R4: same instruction faults in decode and execute, decode kept (2)
      step(1'b1, 4'b0000, 1'b0);
      step(1'b0, 4'b0010, 1'b0);
      step(1'b0, 4'b0100, 1'b0);
      for (int i = 0; i < 4; i++) step(1'b0, 4'b0000, 1'b0);

      // R6: overflow instruction meets interrupt at writeback
      step(1'b1, 4'b0000, 1'b0);
      step(1'b0, 4'b0000, 1'b0);
      step(1'b0, 4'b0100, 1'b0);
      step(1'b0, 4'b0000, 1'b0);
      step(1'b0, 4'b0000, 1'b1);
      step(1'b0, 4'b0000, 1'b0);

      // R11: older overflow beats younger fetch fault
      step(1'b1, 4'b0000, 1'b0);
      step(1'b1, 4'b0001, 1'b0);
      step(1'b0, 4'b0100, 1'b0);
      for (int i = 0; i < 4; i++) step(1'b0, 4'b0000, 1'b0);

      // R9: faults and interrupt on an empty pipeline
      for (int i = 0; i < 6; i++) step(1'b0, 4'b1111, 1'b1);

      // R3 R5 R11: mixed stream
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         r = next_rand();
         step(r[2:0] != 3'd0,
              {r[7:4] == 4'd0, r[11:8] == 4'd0, r[15:12] == 4'd0, r[19:16] == 4'd0},
              r[24:20] == 5'd0);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         fails++;
         $display("FAIL R2 watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule